// File: doc/BRIEF.md
# Zero-Count Parity and Divide-by-Three Tracker

This block watches a serial bit stream and keeps track of how many zero bits have arrived since the last reset. It reports two facts about that count. `odd_zeros` is high when the count is odd. `zeros_div3` is high when the count is a multiple of three, and a count of zero counts as a multiple. Both outputs are Moore outputs, so they come only from the stored state.

The machine has six states. Each state holds the zero count modulo six, which is the product of the parity modulus and the divide-by-three modulus. Each accepted zero moves the state on by one. After the last state it returns to the first. An accepted one leaves the state where it is.

The stream side is a valid-qualified input. When `bit_valid` is high at a rising edge, the block takes `bit_in`. A cycle with `bit_valid` low carries no bit. The block can take one bit in every cycle, so it never applies back-pressure and has no ready output. Reset is synchronous and active high.

Top module: `zero_count_tracker`

## Requirements
- R1: When `rst` is high at a rising edge, the state returns to zero count. From the next cycle `odd_zeros`=0 and `zeros_div3`=1.
- R2: A rising edge with `bit_valid`=1 and `bit_in`=0 raises the stored zero count by one.
- R3: A rising edge with `bit_valid`=1 and `bit_in`=1 leaves both outputs and the state unchanged.
- R4: A rising edge with `bit_valid`=0 leaves the state unchanged, whatever `bit_in` is.
- R5: `odd_zeros` is 1 exactly when the number of zeros accepted since reset is odd.
- R6: `zeros_div3` is 1 exactly when the number of zeros accepted since reset is divisible by three, including zero.
- R7: Starting from reset, successive zeros step the output pair (`odd_zeros`,`zeros_div3`) through 01, 10, 00, 11, 00, 10. The sixth zero returns the pair to 01.
- R8: Both outputs are registered. Each changes only in the cycle after an edge that accepted a zero or applied reset.
- R9: Reset takes priority over a valid zero bit presented at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_valid | input | 1 | Qualifies `bit_in` for this cycle |
| bit_in | input | 1 | Serial data bit |
| odd_zeros | output | 1 | High when the zero count is odd |
| zeros_div3 | output | 1 | High when the zero count is a multiple of three |

## Verification
Every result is due one cycle after its stimulus. An accepted bit or a reset at a rising edge shows on both outputs just after that same edge. The driver task applies inputs on the falling edge. It then updates an unbounded reference counter and queues the expected pair for the coming rising edge. The monitor pops one entry a short delay after each rising edge, so every comparison lines up with the single register stage.

// File: rtl/zc_pkg.sv
package zc_pkg;
  localparam int unsigned PAR_MOD = 2;
  localparam int unsigned DIV_MOD = 3;
  localparam int unsigned RING    = PAR_MOD * DIV_MOD;
  localparam int unsigned CNT_W   = $clog2(RING);

  typedef logic [CNT_W-1:0] ring_t;
endpackage

// File: rtl/zc_step.sv
module zc_step
  import zc_pkg::*;
#(
  parameter int unsigned RING_N = RING
) (
  input  ring_t cur,
  input  logic  adv,
  output ring_t nxt
);
  localparam ring_t LAST = ring_t'(RING_N - 1);

  always_comb begin
    if (!adv)
      nxt = cur;
    else if (cur == LAST)
      nxt = '0;
    else
      nxt = cur + ring_t'(1);
  end
endmodule

// File: rtl/zc_decode.sv
module zc_decode
  import zc_pkg::*;
#(
  parameter int unsigned RING_N = RING,
  parameter int unsigned P_MOD  = PAR_MOD,
  parameter int unsigned D_MOD  = DIV_MOD
) (
  input  ring_t st,
  output logic  par_o,
  output logic  div_o
);
  logic [RING_N-1:0] par_tab;
  logic [RING_N-1:0] div_tab;

  for (genvar s = 0; s < RING_N; s++) begin : g_tab
    assign par_tab[s] = ((s % P_MOD) != 0);
    assign div_tab[s] = ((s % D_MOD) == 0);
  end

  always_comb begin
    par_o = 1'b0;
    div_o = 1'b0;
    for (int i = 0; i < RING_N; i++) begin
      if (st == ring_t'(i)) begin
        par_o = par_tab[i];
        div_o = div_tab[i];
      end
    end
  end
endmodule

// File: rtl/zero_count_tracker.sv
module zero_count_tracker
  import zc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic bit_valid,
  input  logic bit_in,
  output logic odd_zeros,
  output logic zeros_div3
);
  ring_t state_q;
  ring_t state_d;
  logic  take_zero;
  logic  par_w;
  logic  div_w;

  assign take_zero = bit_valid & ~bit_in;

  zc_step #(.RING_N(RING)) u_step (
    .cur (state_q),
    .adv (take_zero),
    .nxt (state_d)
  );

  always_ff @(posedge clk) begin
    if (rst)
      state_q <= '0;
    else
      state_q <= state_d;
  end

  zc_decode #(.RING_N(RING), .P_MOD(PAR_MOD), .D_MOD(DIV_MOD)) u_dec (
    .st    (state_q),
    .par_o (par_w),
    .div_o (div_w)
  );

  assign odd_zeros  = par_w;
  assign zeros_div3 = div_w;

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!odd_zeros && zeros_div3));

  // R3
  hold_on_one_chk: assert property (@(posedge clk) disable iff (rst)
    (bit_valid && bit_in) |=> ($stable(state_q) && $stable(odd_zeros) && $stable(zeros_div3)));

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bit_valid |=> $stable(state_q));

  // R5
  parity_flip_chk: assert property (@(posedge clk) disable iff (rst)
    take_zero |=> (odd_zeros != $past(odd_zeros)));

  // R6
  div3_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (take_zero && zeros_div3) |=> !zeros_div3);

  // R7
  wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (take_zero && state_q == ring_t'(RING - 1)) |=> (state_q == '0));
endmodule

// File: tb/test_zero_count_tracker.sv
module test_zero_count_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_valid = 1'b0;
  logic bit_in = 1'b0;
  logic odd_zeros;
  logic zeros_div3;

  int checks = 0;
  int errors = 0;
  int ref_cnt = 0;
  int cycles = 0;
  bit done = 1'b0;

  logic [1:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  zero_count_tracker i_zero_count_tracker (
    .clk        (clk),
    .rst        (rst),
    .bit_valid  (bit_valid),
    .bit_in     (bit_in),
    .odd_zeros  (odd_zeros),
    .zeros_div3 (zeros_div3)
  );

  task automatic step(input logic r, input logic v, input logic b, input string tag);
    @(negedge clk);
    rst = r; bit_valid = v; bit_in = b;
    if (r) ref_cnt = 0;
    else if (v && !b) ref_cnt++;
    exp_q.push_back({logic'(ref_cnt % 2 == 1), logic'(ref_cnt % 3 == 0)});
    tag_q.push_back(tag);
  endtask

  // monitor: compare one queued expectation per rising edge
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (odd_zeros !== e[1]) begin
        errors++;
        $display("FAIL %s/R5 odd_zeros actual=%b expected=%b", t, odd_zeros, e[1]);
      end
      checks++;
      if (zeros_div3 !== e[0]) begin
        errors++;
        $display("FAIL %s/R6 zeros_div3 actual=%b expected=%b", t, zeros_div3, e[0]);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      errors++;
      $display("FAIL watchdog actual=%0d cycles expected<=%0d", cycles, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] lfsr;
    lfsr = 8'hA5;
    // R1: reset state
    step(1, 0, 0, "R1");
    step(1, 0, 0, "R1");
    // R7 / R2: walk the ring twice with back-to-back zeros
    for (int i = 0; i < 13; i++) step(0, 1, 0, "R7");
    // R3 / R8: ones hold the state
    for (int i = 0; i < 4; i++) step(0, 1, 1, "R3");
    step(0, 1, 0, "R2");
    // R4: invalid cycles ignored even with bit_in=0
    for (int i = 0; i < 4; i++) step(0, 0, 0, "R4");
    step(0, 0, 1, "R4");
    step(0, 1, 0, "R2");
    // R9: reset wins over a valid zero
    step(1, 1, 0, "R9");
    step(0, 1, 1, "R8");
    step(0, 1, 0, "R2");
    // R5 / R6: mixed pseudo-random pattern
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      step(0, lfsr[0] | lfsr[3], lfsr[1], "R5R6");
    end
    // R1 again mid-stream
    step(1, 0, 1, "R1");
    for (int i = 0; i < 3; i++) step(0, 1, 0, "R7");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule